// File: doc/BRIEF.md
# Bridge PWM Output Steering Unit

This unit makes one pulse-width waveform and routes it onto four output channels, A to D, so that a load can be driven single-ended, from a half-bridge or from a full bridge in either direction. An internal period counter advances on an enable tick. The duty value is built from a wide upper part and a narrow lower part. A new duty value is latched only when a period begins.

A 2-bit steering field picks the routing. A 2-bit polarity field sets the active level of pair A/C and pair B/D independently. In half-bridge routing, A and B form a complementary pair. The rising edge of each is held back by a programmable dead-band count, so the two switches never conduct at the same time.

A shutdown input forces every PWM-owned channel to its inactive level. Each channel also has a flag that shows whether the PWM currently owns it; a channel that is not owned is driven low.

Top module: `pwm_bridge_steer`

## Requirements
- R1: While rst_ni is low, pin_o and own_o are all zero.
- R2: The period lasts period_i+1 ticks. The modulated signal is active for the first D counts of each period, where D = {duty_hi_i, duty_lo_i}. If D exceeds period_i+1, the signal is active for the whole period.
- R3: A change on the duty inputs takes effect only at the next period start. The period in progress keeps its duty.
- R4: Steering 2'b00: only A is modulated; B, C and D are released.
- R5: Steering 2'b01: D is modulated, A is held active, and B and C are held inactive.
- R6: Steering 2'b10: A carries the modulated signal and B its complement. Each channel's rising edge is delayed by dead_i clock cycles. C and D are released.
- R7: In steering 2'b10, A and B are never active in the same cycle.
- R8: Steering 2'b11: B is modulated, C is held active, and A and D are held inactive.
- R9: pol_i[1]=1 makes A and C active-low. pol_i[0]=1 makes B and D active-low.
- R10: One clock after shutdown_i is high, every owned channel is at its inactive level. The channels stay there until shutdown_i is low and a new period has begun.
- R11: own_o (bit 0=A, 1=B, 2=C, 3=D) is 4'b0001 for 2'b00, 4'b1111 for 2'b01 and 2'b11, and 4'b0011 for 2'b10.
- R12: A channel whose own_o bit is 0 drives pin_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Advances the period counter |
| period_i | input | 10 | Last count of the period |
| duty_hi_i | input | 8 | Upper bits of the duty value |
| duty_lo_i | input | 2 | Lower bits of the duty value |
| cfg_i | input | 2 | Steering selection |
| pol_i | input | 2 | Active-low select: bit 1 for A/C, bit 0 for B/D |
| dead_i | input | 8 | Dead-band delay in clock cycles |
| shutdown_i | input | 1 | Forces owned channels inactive |
| pin_o | output | 4 | Channel outputs, bit 0 = A |
| own_o | output | 4 | Channel owned by the PWM |

## Verification
The assertions assume that the period, polarity and steering inputs are quasi-static. They may change between cycles, but the checks relate only cycle-adjacent values. The counter check also assumes that a tick at or past the period limit always restarts the count. The stimulus holds the steering, polarity, period and dead-band values fixed within each random phase. It changes only the duty value, the tick pattern and short shutdown pulses at random. The duty value is drawn up to two counts beyond the period, so the saturated case is also exercised.

// File: rtl/pwm_bridge_pkg.sv
package pwm_bridge_pkg;
  typedef enum logic [1:0] {
    CFG_SINGLE = 2'b00,
    CFG_FWD    = 2'b01,
    CFG_HALF   = 2'b10,
    CFG_REV    = 2'b11
  } bridge_cfg_e;

  localparam int unsigned CH_N = 4;
  localparam int unsigned CH_A = 0;
  localparam int unsigned CH_B = 1;
  localparam int unsigned CH_C = 2;
  localparam int unsigned CH_D = 3;
endpackage

// File: rtl/pwm_bridge_core.sv
module pwm_bridge_core #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o,
  output logic             pstart_o
);
  logic [CNT_W-1:0] cnt_q, duty_q;
  logic             wrap;

  assign wrap     = (cnt_q >= period_i);
  assign pstart_o = tick_i & wrap;
  assign pwm_o    = (cnt_q < duty_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      duty_q <= '0;
    end else if (tick_i) begin
      if (wrap) begin
        cnt_q  <= '0;
        duty_q <= duty_i;   // double-buffered duty
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wrap) |=> (cnt_q == '0));
  assert_duty_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pstart_o |=> $stable(duty_q));
endmodule

// File: rtl/pwm_bridge_deadband.sv
module pwm_bridge_deadband #(
  parameter int unsigned DB_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_i,
  input  logic [DB_W-1:0] dead_i,
  output logic            out_o
);
  logic [DB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (!in_i) begin
      cnt_q <= '0;
      out_o <= 1'b0;
    end else if (cnt_q >= dead_i) begin
      out_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_fall_fast_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_i |=> !out_o);
endmodule

// File: rtl/pwm_bridge_route.sv
module pwm_bridge_route
  import pwm_bridge_pkg::*;
(
  input  logic [1:0]      cfg_i,
  input  logic [1:0]      pol_i,
  input  logic            force_i,
  input  logic            raw_i,
  input  logic [1:0]      dly_i,
  output logic [CH_N-1:0] pin_o,
  output logic [CH_N-1:0] own_o
);
  logic [CH_N-1:0] act, lvl;

  always_comb begin
    act   = '0;
    own_o = '0;
    unique case (bridge_cfg_e'(cfg_i))
      CFG_SINGLE: begin
        own_o      = 4'b0001;
        act[CH_A]  = raw_i;
      end
      CFG_FWD: begin
        own_o      = 4'b1111;
        act[CH_A]  = 1'b1;
        act[CH_D]  = raw_i;
      end
      CFG_HALF: begin
        own_o      = 4'b0011;
        act[CH_A]  = dly_i[0];
        act[CH_B]  = dly_i[1];
      end
      CFG_REV: begin
        own_o      = 4'b1111;
        act[CH_B]  = raw_i;
        act[CH_C]  = 1'b1;
      end
      default: ;
    endcase
    if (force_i) act = '0;
  end

  generate
    for (genvar g = 0; g < CH_N; g++) begin : g_lvl
      // even channels (A, C) follow pol bit 1, odd (B, D) follow bit 0
      assign lvl[g] = (g % 2 == 0) ? pol_i[1] : pol_i[0];
    end
  endgenerate

  assign pin_o = (act ^ lvl) & own_o;
endmodule

// File: rtl/pwm_bridge_steer.sv
module pwm_bridge_steer
  import pwm_bridge_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned LO_W  = 2,
  parameter int unsigned DB_W  = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic [CNT_W-1:0]      period_i,
  input  logic [CNT_W-LO_W-1:0] duty_hi_i,
  input  logic [LO_W-1:0]       duty_lo_i,
  input  logic [1:0]            cfg_i,
  input  logic [1:0]            pol_i,
  input  logic [DB_W-1:0]       dead_i,
  input  logic                  shutdown_i,
  output logic [CH_N-1:0]       pin_o,
  output logic [CH_N-1:0]       own_o
);
  logic            raw, pstart, sd_q, force_off;
  logic [1:0]      dly;
  logic [CH_N-1:0] pin_d, own_d;

  pwm_bridge_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .period_i (period_i),
    .duty_i   ({duty_hi_i, duty_lo_i}),
    .pwm_o    (raw),
    .pstart_o (pstart)
  );

  generate
    for (genvar g = 0; g < 2; g++) begin : g_db
      pwm_bridge_deadband #(.DB_W(DB_W)) u_db (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .in_i   ((g == 0) ? raw : ~raw),
        .dead_i (dead_i),
        .out_o  (dly[g])
      );
    end
  endgenerate

  // shutdown latches until released and the next period starts
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sd_q <= 1'b0;
    else if (shutdown_i) sd_q <= 1'b1;
    else if (pstart)     sd_q <= 1'b0;
  end
  assign force_off = shutdown_i | sd_q;

  pwm_bridge_route u_route (
    .cfg_i   (cfg_i),
    .pol_i   (pol_i),
    .force_i (force_off),
    .raw_i   (raw),
    .dly_i   (dly),
    .pin_o   (pin_d),
    .own_o   (own_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_o <= '0;
      own_o <= '0;
    end else begin
      pin_o <= pin_d;
      own_o <= own_d;
    end
  end

  assert_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dly[0] && dly[1]));
  assert_sd_inactive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_i |=> ((pin_o & own_o) ==
      ({$past(pol_i[0]), $past(pol_i[1]), $past(pol_i[0]), $past(pol_i[1])} & own_o)));
  assert_released_low_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~own_o) == '0);
endmodule

// File: tb/pwm_bridge_steer_tb.sv
module pwm_bridge_steer_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WATCHDOG   = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [9:0] period_i = '0;
  logic [7:0] duty_hi_i = '0;
  logic [1:0] duty_lo_i = '0;
  logic [1:0] cfg_i = '0;
  logic [1:0] pol_i = '0;
  logic [7:0] dead_i = '0;
  logic       shutdown_i = 1'b0;
  logic [3:0] pin_o, own_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  string tag = "R4";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_bridge_steer u_dut (
    .clk_i, .rst_ni, .tick_i, .period_i, .duty_hi_i, .duty_lo_i,
    .cfg_i, .pol_i, .dead_i, .shutdown_i, .pin_o, .own_o
  );

  // reference state
  logic [9:0] m_cnt, m_duty;
  logic       m_sd, m_da, m_db;
  logic [7:0] m_ca, m_cb;
  logic [3:0] m_pin, m_own;

  function automatic logic [3:0] ref_own(logic [1:0] c);
    case (c)
      2'b00:   return 4'b0001;
      2'b10:   return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [3:0] ref_pin(logic [1:0] c, logic [1:0] p, logic f,
                                         logic r, logic a, logic b);
    logic [3:0] act;
    act = '0;
    case (c)
      2'b00: act[0] = r;
      2'b01: begin act[0] = 1'b1; act[3] = r; end
      2'b10: begin act[0] = a; act[1] = b; end
      2'b11: begin act[1] = r; act[2] = 1'b1; end
    endcase
    if (f) act = '0;
    return (act ^ {p[0], p[1], p[0], p[1]}) & ref_own(c);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = '0; m_duty = '0; m_sd = 0; m_da = 0; m_db = 0;
      m_ca = '0; m_cb = '0; m_pin = '0; m_own = '0;
    end else begin
      logic raw, ps;
      raw   = m_cnt < m_duty;
      ps    = tick_i && (m_cnt >= period_i);
      m_pin = ref_pin(cfg_i, pol_i, shutdown_i | m_sd, raw, m_da, m_db);
      m_own = ref_own(cfg_i);
      if (!raw) begin m_ca = '0; m_da = 0; end
      else if (m_ca >= dead_i) m_da = 1;
      else m_ca = m_ca + 1;
      if (raw) begin m_cb = '0; m_db = 0; end
      else if (m_cb >= dead_i) m_db = 1;
      else m_cb = m_cb + 1;
      if (shutdown_i) m_sd = 1;
      else if (ps) m_sd = 0;
      if (tick_i) begin
        if (ps) begin m_cnt = '0; m_duty = {duty_hi_i, duty_lo_i}; end
        else m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic check(string t, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cycle %0d got %b expected %b", t, cyc, act, exp);
    end
  endtask

  task automatic cmp_model();
    check({tag, "/R9"}, pin_o, m_pin);
    check("R11", own_o, m_own);
    check("R12", pin_o & ~own_o, 4'b0000);
    if (cfg_i == 2'b10 && own_o == 4'b0011)
      check("R7", {3'b000, (pin_o[0] ^ pol_i[1]) & (pin_o[1] ^ pol_i[0])}, 4'b0000);
  endtask

  task automatic set_duty(int d);
    duty_hi_i = 8'(d >> 2);
    duty_lo_i = 2'(d);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: cycle %0d got hang expected done", cyc);
      finish_run();
    end
  end

  initial begin
    int cnt_hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R1", pin_o, 4'b0000);
    check("R1", own_o, 4'b0000);
    rst_ni = 1'b1;

    // R2: duty 6 of a 10-cycle period on A
    cfg_i = 2'b00; pol_i = 2'b00; period_i = 10'd9; set_duty(6); tick_i = 1'b1;
    repeat (30) @(negedge clk_i);
    cnt_hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk_i); cnt_hi += pin_o[0]; end
    check("R2", 4'(cnt_hi), 4'd6);
    set_duty(15);
    repeat (30) @(negedge clk_i);
    cnt_hi = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk_i); cnt_hi += pin_o[0]; end
    check("R2", 4'(cnt_hi), 4'd10);

    // R3: duty change mid-period tracked by the reference
    tag = "R3";
    set_duty(2);
    repeat (4) @(negedge clk_i);
    set_duty(8);
    for (int i = 0; i < 25; i++) begin @(negedge clk_i); cmp_model(); end

    // R10: directed shutdown, forward bridge, A/C active-low
    tag = "R10";
    cfg_i = 2'b01; pol_i = 2'b10; set_duty(5);
    repeat (25) @(negedge clk_i);
    shutdown_i = 1'b1;
    @(negedge clk_i);
    check("R10", pin_o, 4'b0101);
    shutdown_i = 1'b0;
    @(negedge clk_i);
    check("R10", pin_o, 4'b0101);
    for (int i = 0; i < 25; i++) begin @(negedge clk_i); cmp_model(); end

    // random phases over every routing and polarity
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 4; p++) begin
        int per;
        cfg_i = 2'(c); pol_i = 2'(p);
        case (c) 0: tag = "R4"; 1: tag = "R5"; 2: tag = "R6"; default: tag = "R8"; endcase
        per = 3 + $urandom % 13;
        period_i = 10'(per);
        dead_i = 8'($urandom % 4);
        set_duty($urandom % (per + 3));
        for (int i = 0; i < 1500; i++) begin
          @(negedge clk_i);
          cmp_model();
          tick_i = (p[0]) ? 1'b1 : ($urandom % 4 != 0);
          if ($urandom % 40 == 0) set_duty($urandom % (per + 3));
          shutdown_i = ($urandom % 60 == 0);
        end
        shutdown_i = 1'b0;
      end
    end
    finish_run();
  end
endmodule